// File: doc/BRIEF.md
# Twisted-Ring Counter with One-Hot State Decode

This block is a shift-register counter of `STAGES` flip-flops closed into a loop with an inversion. The first stage loads the complement of the last stage and every other stage loads its neighbour. Started from all zeros, the register fills with ones from the first stage towards the last and then empties the same way. It visits `2*STAGES` distinct patterns before it repeats.

Next to the counter sits a decoder that names the current pattern on a `2*STAGES`-bit one-hot bus. Each output bit is one two-input AND of a pair of stage outputs: neighbouring stages, or the first and last stage. No full-width compare is used. Typical uses are phase generators and sequencers that need a glitch-tolerant, evenly spaced set of strobes. A synchronous clear puts the counter at pattern 0. An enable lets it advance or hold.

Top module: `twr_johnson_top`

## Requirements
- R1: While `clr` is high at a rising clock edge, every stage becomes 0 after that edge and `state_hot` reads 1 (bit 0 set alone).
- R2: On an enabled edge without clear, stage 0 takes the inverse of stage `STAGES-1`.
- R3: On an enabled edge without clear, stage k (k ≥ 1) takes the old value of stage k-1.
- R4: From clear, with the default 4 stages and `stages` read as bits [3:0], the enabled sequence is 0000, 0001, 0011, 0111, 1111, 1110, 1100, 1000. It then returns to 0000, giving `2*STAGES` distinct patterns per period.
- R5: When `en` is low and `clr` is low, `stages` and `state_hot` keep their values.
- R6: In every pattern reached from clear, `state_hot` has exactly one bit set.
- R7: `state_hot` bit p is set when the counter has made p enabled steps (mod `2*STAGES`) since the last clear. Pattern 0 is ~s[0]·~s[N-1]. Pattern k (1≤k≤N-1) is s[k-1]·~s[k]. Pattern N is s[0]·s[N-1]. Pattern N+k is ~s[k-1]·s[k]. Each enabled step therefore rotates `state_hot` left by one place.
- R8: Clear takes priority over enable when both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous active-high clear to pattern 0 |
| en | input | 1 | Advance one step per edge when high |
| stages | output | STAGES | Registered stage outputs, bit 0 is the first stage |
| state_hot | output | 2*STAGES | One-hot pattern indication |

## Verification
The bench builds two copies side by side: one with the default 4 stages and one with 3 stages. The odd-width copy exercises the generalised decode terms and a wrap at 6 patterns, in addition to the literal 8-pattern sequence of the default build. A behavioural step counter drives the expected value of both outputs on every clock. It covers two full periods of uninterrupted counting, gapped enables, a clear that arrives in mid-sequence together with enable, and held stretches.

// File: rtl/twr_pkg.sv
package twr_pkg;

  // number of distinct patterns visited by a twisted ring of the given length
  function automatic int twr_state_count(input int stage_cnt);
    return 2 * stage_cnt;
  endfunction

endpackage

// File: rtl/twr_stage_chain.sv
module twr_stage_chain #(
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              en,
  output logic [STAGES-1:0] q
);

  logic [STAGES-1:0] nxt;

  // loop-back with inversion at the head, plain shift everywhere else
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_link
      if (i == 0) begin : g_head
        assign nxt[i] = ~q[STAGES-1];
      end else begin : g_body
        assign nxt[i] = q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (clr) begin
      q <= '0;
    end else if (en) begin
      q <= nxt;
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (clr)
    $past(clr) |-> (q == '0)); // R1

  AST_HOLD: assert property (@(posedge clk) disable iff (clr)
    !en |=> $stable(q)); // R5

  AST_FEED_INV: assert property (@(posedge clk) disable iff (clr)
    en |=> (q[0] == !$past(q[STAGES-1]))); // R2

  AST_SHIFT: assert property (@(posedge clk) disable iff (clr)
    en |=> (q[STAGES-1:1] == $past(q[STAGES-2:0]))); // R3

endmodule

// File: rtl/twr_decoder.sv
module twr_decoder #(
  parameter int STAGES = 4,
  localparam int STATES = twr_pkg::twr_state_count(STAGES)
) (
  input  logic [STAGES-1:0] q,
  output logic [STATES-1:0] hot
);

  // each pattern is named by one two-input AND on adjacent or end stages
  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_term
      if (k == 0) begin : g_ends
        assign hot[0]      = ~q[0] & ~q[STAGES-1];
        assign hot[STAGES] =  q[0] &  q[STAGES-1];
      end else begin : g_edge
        assign hot[k]        =  q[k-1] & ~q[k];
        assign hot[STAGES+k] = ~q[k-1] &  q[k];
      end
    end
  endgenerate

endmodule

// File: rtl/twr_johnson_top.sv
module twr_johnson_top #(
  parameter int STAGES = 4,
  localparam int STATES = twr_pkg::twr_state_count(STAGES)
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              en,
  output logic [STAGES-1:0] stages,
  output logic [STATES-1:0] state_hot
);

  twr_stage_chain #(.STAGES(STAGES)) u_chain (
    .clk (clk),
    .clr (clr),
    .en  (en),
    .q   (stages)
  );

  twr_decoder #(.STAGES(STAGES)) u_decode (
    .q   (stages),
    .hot (state_hot)
  );

  AST_ONE_HOT: assert property (@(posedge clk) disable iff (clr)
    $countones(state_hot) == 1); // R6

  AST_HOT_ROTATE: assert property (@(posedge clk) disable iff (clr)
    en |=> (state_hot == {$past(state_hot[STATES-2:0]), $past(state_hot[STATES-1])})); // R7

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (clr)
    $past(clr && en) |-> (state_hot == STATES'(1))); // R8

endmodule

// File: tb/test_twr_johnson_top.sv
`timescale 1ns/1ps
module test_twr_johnson_top;

  logic clk = 1'b0;
  logic clr = 1'b1;
  logic en  = 1'b0;

  logic [3:0] q4;
  logic [7:0] hot4;
  logic [2:0] q3;
  logic [5:0] hot3;

  always #2.5 clk = ~clk;

  twr_johnson_top #(.STAGES(4)) i_twr_johnson_top (
    .clk(clk), .clr(clr), .en(en), .stages(q4), .state_hot(hot4));

  twr_johnson_top #(.STAGES(3)) i_twr_johnson_top_n3 (
    .clk(clk), .clr(clr), .en(en), .stages(q3), .state_hot(hot3));

  int total = 0;
  int bad = 0;
  int pos4 = 0;
  int pos3 = 0;
  logic armed = 1'b0;
  logic done = 1'b0;
  logic prev_en = 1'b0;
  logic prev_clr = 1'b0;
  logic [3:0] q4_prev = '0;
  logic [7:0] hot4_prev = '0;

  // expected stage pattern after p steps in an n-stage ring
  function automatic logic [7:0] exp_q(int n, int p);
    logic [7:0] v = '0;
    for (int i = 0; i < n; i++) begin
      if (p < n) v[i] = (i < p);
      else       v[i] = (i >= p - n);
    end
    return v;
  endfunction

  function automatic logic [7:0] seq4(int p);
    case (p)
      0: return 8'b0000;
      1: return 8'b0001;
      2: return 8'b0011;
      3: return 8'b0111;
      4: return 8'b1111;
      5: return 8'b1110;
      6: return 8'b1100;
      default: return 8'b1000;
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // behavioural reference: a step count per ring
  always @(posedge clk) begin
    prev_en   <= en;
    prev_clr  <= clr;
    q4_prev   <= q4;
    hot4_prev <= hot4;
    if (clr) begin
      pos4  <= 0;
      pos3  <= 0;
      armed <= 1'b1;
    end else if (en) begin
      pos4 <= (pos4 + 1) % 8;
      pos3 <= (pos3 + 1) % 6;
    end
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      if (prev_clr && prev_en) begin
        chk("R8 stages", {4'b0, q4}, 8'h00);
        chk("R8 state_hot", hot4, 8'h01);
      end else if (prev_clr) begin
        chk("R1 stages", {4'b0, q4}, 8'h00);
        chk("R1 state_hot", hot4, 8'h01);
      end else if (!prev_en) begin
        chk("R5 stages held", {4'b0, q4}, {4'b0, q4_prev});
        chk("R5 state_hot held", hot4, hot4_prev);
      end else begin
        chk("R2 R3 stages n4", {4'b0, q4}, exp_q(4, pos4));
        chk("R2 R3 stages n3", {5'b0, q3}, exp_q(3, pos3));
      end
      chk("R4 sequence n4", {4'b0, q4}, seq4(pos4));
      chk("R6 one-hot n4", 8'($countones(hot4)), 8'd1);
      chk("R6 one-hot n3", 8'($countones(hot3)), 8'd1);
      chk("R7 decode n4", hot4, 8'(1 << pos4));
      chk("R7 decode n3", {2'b0, hot3}, 8'(1 << pos3));
    end
  end

  task automatic step(logic c, logic e);
    @(negedge clk);
    #1;
    clr = c;
    en  = e;
  endtask

  initial begin
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1);
    for (int i = 0; i < 12; i++) step(1'b0, (i % 3) != 0);
    step(1'b1, 1'b1);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    for (int i = 0; i < 18; i++) step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    @(negedge clk);
    #1;
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule